// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It does this by reading a two-level translation table out of memory, one 32-bit word at a time. A request carries the linear address together with the physical address of the directory that belongs to the current address space. Reloading that base value between requests gives every process its own mapping.

The top ten linear bits select a directory entry. If that entry has its large-page flag set, the walk stops after one read and the entry names a 4 MB frame. Otherwise the entry points to a 4 KB aligned second-level table. The middle ten linear bits select a word in that table, and that word names a 4 KB frame. Both page sizes can appear in the same directory.

Bit 0 of every entry is a present flag. A clear present flag at either level ends the walk with a fault.

Memory is reached through a single read port. The port holds a request and its address until the memory accepts it, and the read data comes back later on a valid strobe. The block keeps at most one read in flight. Each result is reported for exactly one cycle.

Top module: `page_walker`

## Requirements
- R1: The first read of every walk goes to the request's directory base (with bits 1:0 forced to zero) plus four times linear bits 31:22.
- R2: For a directory entry with bit 0 = 1 and bit 7 = 0, a second read goes to {entry[31:12], 12'h000} plus four times linear bits 21:12. The result is {second entry[31:12], linear[11:0]}, and flag bits 11:1 of either entry do not change it.
- R3: For a directory entry with bit 0 = 1 and bit 7 = 1, the walk makes exactly one read. The result is {entry[31:22], linear[21:0]}, and entry bits 21:1 do not change it.
- R4: The page size is decided separately for each directory entry, so small-page and large-page walks through the same directory each give their own correct result.
- R5: The directory base is sampled only in the cycle a request is accepted. A change on the base input during a walk has no effect on that walk, and the next request uses its own base.
- R6: A directory entry with bit 0 = 0 ends the walk after that single read, with doneFault = 1 and donePhys = 0. This holds even when bit 7 is set.
- R7: A table entry with bit 0 = 0 ends the walk after two reads, with doneFault = 1 and donePhys = 0.
- R8: At most one read is outstanding. memReq and memAddr stay unchanged until memReady is seen. Every memAddr has bits 1:0 equal to zero. A 4 KB walk makes exactly two reads.
- R9: reqReady is high only while idle. doneValid is high for exactly one cycle per walk, and reqReady is high again in the following cycle.
- R10: After reset, reqReady = 1, memReq = 0 and doneValid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translate request |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqLinear | input | 32 | Linear address to translate |
| reqBase | input | 32 | Physical address of the directory for this request |
| memReq | output | 1 | Read request to memory |
| memAddr | output | 32 | Word address of the entry to read |
| memReady | input | 1 | Memory accepts the read request |
| memValid | input | 1 | Read data is valid |
| memData | input | 32 | Read data (one table entry) |
| doneValid | output | 1 | Result strobe, one cycle |
| doneFault | output | 1 | Walk ended on an absent entry |
| donePhys | output | 32 | Translated physical address, zero on a fault |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, ten index bits per level, a 12-bit page offset, the present flag at bit 0 and the large-page flag at bit 7. With these values it can place small and large entries side by side in a sparse memory, flag-polluted entries, absent entries at both levels, and two directories at different bases. Memory latency and acceptance delay are varied from read to read, so the address-hold and single-outstanding rules are exercised. On top of this, base and address inputs are corrupted as soon as each request is accepted.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_PDE,
    ST_WAIT_PDE,
    ST_READ_PTE,
    ST_WAIT_PTE,
    ST_DONE
  } walk_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldReq;     // capture linear address and directory base
    logic ldPde;     // keep table base from the directory entry
    logic ldSmall;   // compose a 4 KB result
    logic ldLarge;   // compose a 4 MB result
    logic ldFault;   // record a fault
    logic selTable;  // address the second-level table
  } walk_strobe_t;

endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memReady,
  input  logic         memValid,
  input  logic         entPresent,
  input  logic         entLarge,
  output walk_strobe_t strb,
  output logic         reqReady,
  output logic         memReq,
  output logic         doneValid
);

  walk_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    doneValid = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.ldReq = 1'b1;
          stateNext  = ST_READ_PDE;
        end
      end
      ST_READ_PDE: begin
        memReq = 1'b1;
        if (memReady) stateNext = ST_WAIT_PDE;
      end
      ST_WAIT_PDE: begin
        if (memValid) begin
          if (!entPresent) begin
            strb.ldFault = 1'b1;
            stateNext    = ST_DONE;
          end else if (entLarge) begin
            strb.ldLarge = 1'b1;
            stateNext    = ST_DONE;
          end else begin
            strb.ldPde   = 1'b1;
            stateNext    = ST_READ_PTE;
          end
        end
      end
      ST_READ_PTE: begin
        memReq        = 1'b1;
        strb.selTable = 1'b1;
        if (memReady) stateNext = ST_WAIT_PTE;
      end
      ST_WAIT_PTE: begin
        if (memValid) begin
          strb.ldFault = !entPresent;
          strb.ldSmall = entPresent;
          stateNext    = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pw_dpath.sv
module pw_dpath
  import pw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int OFS_W       = 12,
  parameter int PRESENT_BIT = 0,
  parameter int LARGE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_strobe_t      strb,
  input  logic [ADDR_W-1:0] reqLinear,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              entPresent,
  output logic              entLarge,
  output logic              doneFault,
  output logic [ADDR_W-1:0] donePhys
);

  localparam int DIR_LO  = OFS_W + IDX_W;     // lowest directory-index bit
  localparam int DIR_W   = ADDR_W - DIR_LO;   // directory-index width
  localparam int ENT_SH  = 2;                 // log2 of entry bytes
  localparam int FRAME_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0]  linReg;
  logic [ADDR_W-1:0]  baseReg;
  logic [FRAME_W-1:0] tblBase;
  logic [ADDR_W-1:0]  physReg;
  logic               faultReg;

  logic [DIR_W-1:0]   dirIdx;
  logic [IDX_W-1:0]   tblIdx;
  logic [ADDR_W-1:0]  dirAddr;
  logic [ADDR_W-1:0]  tblAddr;

  assign dirIdx  = linReg[ADDR_W-1:DIR_LO];
  assign tblIdx  = linReg[DIR_LO-1:OFS_W];
  assign dirAddr = {baseReg[ADDR_W-1:ENT_SH], ENT_SH'(0)} + ADDR_W'({dirIdx, ENT_SH'(0)});
  assign tblAddr = {tblBase, OFS_W'(0)} + ADDR_W'({tblIdx, ENT_SH'(0)});
  assign memAddr = strb.selTable ? tblAddr : dirAddr;

  assign entPresent = memData[PRESENT_BIT];
  assign entLarge   = memData[LARGE_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linReg   <= '0;
      baseReg  <= '0;
      tblBase  <= '0;
      physReg  <= '0;
      faultReg <= 1'b0;
    end else begin
      if (strb.ldReq) begin
        linReg  <= reqLinear;
        baseReg <= reqBase;
      end
      if (strb.ldPde) tblBase <= memData[ADDR_W-1:OFS_W];
      if (strb.ldLarge) begin
        physReg  <= {memData[ADDR_W-1:DIR_LO], linReg[DIR_LO-1:0]};
        faultReg <= 1'b0;
      end else if (strb.ldSmall) begin
        physReg  <= {memData[ADDR_W-1:OFS_W], linReg[OFS_W-1:0]};
        faultReg <= 1'b0;
      end else if (strb.ldFault) begin
        physReg  <= '0;
        faultReg <= 1'b1;
      end
    end
  end

  assign doneFault = faultReg;
  assign donePhys  = physReg;

  // flag bits of entries and low base bits carry no meaning here
  logic unusedBits;
  assign unusedBits = ^{memData, baseReg[ENT_SH-1:0]};

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int OFS_W       = 12,
  parameter int PRESENT_BIT = 0,
  parameter int LARGE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqLinear,
  input  logic [ADDR_W-1:0] reqBase,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memData,
  output logic              doneValid,
  output logic              doneFault,
  output logic [ADDR_W-1:0] donePhys
);

  walk_strobe_t strb;
  logic         entPresent;
  logic         entLarge;

  pw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memReady   (memReady),
    .memValid   (memValid),
    .entPresent (entPresent),
    .entLarge   (entLarge),
    .strb       (strb),
    .reqReady   (reqReady),
    .memReq     (memReq),
    .doneValid  (doneValid)
  );

  pw_dpath #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .OFS_W       (OFS_W),
    .PRESENT_BIT (PRESENT_BIT),
    .LARGE_BIT   (LARGE_BIT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqLinear  (reqLinear),
    .reqBase    (reqBase),
    .memData    (memData),
    .memAddr    (memAddr),
    .entPresent (entPresent),
    .entLarge   (entLarge),
    .doneFault  (doneFault),
    .donePhys   (donePhys)
  );

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady,
  input logic              memValid,
  input logic              doneValid,
  input logic              doneFault,
  input logic [ADDR_W-1:0] donePhys
);

  logic [1:0] outCnt;

  always_ff @(posedge clk) begin
    if (!rstN) outCnt <= '0;
    else if (memReq && memReady && !memValid) outCnt <= outCnt + 2'd1;
    else if (memValid && !(memReq && memReady) && outCnt != 2'd0) outCnt <= outCnt - 2'd1;
  end

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= 2'd1);

  assert_req_only_when_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> outCnt == 2'd0);

  assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr));

  assert_fault_no_phys_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault |-> donePhys == '0);

  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && reqReady);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

endmodule

bind page_walker pw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memReady  (memReady),
  .memValid  (memValid),
  .doneValid (doneValid),
  .doneFault (doneFault),
  .donePhys  (donePhys)
);

// File: tb/sim_page_walker.sv
`timescale 1ns/1ps
module sim_page_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqLinear = '0;
  logic [31:0] reqBase = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memReady = 1'b0;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        doneValid;
  logic        doneFault;
  logic [31:0] donePhys;

  always #2 clk = ~clk;   // 250 MHz

  page_walker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLinear(reqLinear), .reqBase(reqBase), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memValid(memValid), .memData(memData),
    .doneValid(doneValid), .doneFault(doneFault), .donePhys(donePhys)
  );

  typedef struct {
    logic        fault;
    logic [31:0] phys;
    int          nReads;
    logic [31:0] addr0;
    string       tag;
  } exp_t;

  logic [31:0] mem [logic [31:0]];
  exp_t        sbq[$];
  logic [31:0] readLog[$];
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  int          rdCount = 0;
  bit          pendReady = 0;

  localparam logic [31:0] DIR_A = 32'h0010_0000;
  localparam logic [31:0] DIR_B = 32'h0020_0000;
  localparam logic [31:0] TBL_A = 32'h0030_0000;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference translation from the requirements
  function automatic exp_t refWalk(logic [31:0] lin, logic [31:0] base, string tag);
    exp_t e;
    logic [31:0] pde, pte, a1;
    e.addr0 = {base[31:2], 2'b00} + {20'h0, lin[31:22], 2'b00};
    pde = rd(e.addr0);
    e.phys = '0; e.fault = 1'b0; e.nReads = 1;
    if (!pde[0]) begin
      e.fault = 1'b1; e.tag = "R6";
    end else if (pde[7]) begin
      e.phys = {pde[31:22], lin[21:0]}; e.tag = "R3";
    end else begin
      e.nReads = 2;
      a1 = {pde[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00};
      pte = rd(a1);
      if (!pte[0]) begin e.fault = 1'b1; e.tag = "R7"; end
      else begin e.phys = {pte[31:12], lin[11:0]}; e.tag = "R2"; end
    end
    if (tag != "") e.tag = {tag, "/", e.tag};
    return e;
  endfunction

  // Driver: push expected result, present request, then corrupt inputs
  task automatic translate(logic [31:0] lin, logic [31:0] base, string tag);
    exp_t e;
    e = refWalk(lin, base, tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid  = 1'b1;
    reqLinear = lin;
    reqBase   = base;
    sbq.push_back(e);
    @(negedge clk);
    reqValid  = 1'b0;
    reqBase   = ~base;   // R5: must be ignored during the walk
    reqLinear = ~lin;
    check(reqReady == 1'b0, "R9", "ready while walking", {31'h0, reqReady}, 32'h0);
  endtask

  // Memory responder with varying accept delay and latency
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      if (rstN && memReq) begin
        repeat (rdCount % 3) @(negedge clk);
        a = memAddr;
        memReady = 1'b1;
        readLog.push_back(a);
        @(negedge clk);
        memReady = 1'b0;
        repeat ((rdCount + 1) % 2) @(negedge clk);
        memValid = 1'b1;
        memData  = rd(a);
        @(negedge clk);
        memValid = 1'b0;
        memData  = 32'hDEAD_BEEF;
        rdCount++;
      end
    end
  end

  // Monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (pendReady) begin
        check(reqReady && !doneValid, "R9", "ready after done",
              {30'h0, doneValid, reqReady}, 32'h1);
        pendReady = 0;
      end
      if (doneValid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R9", "unexpected done", donePhys, 32'h0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(doneFault == e.fault, e.tag, "fault", {31'h0, doneFault}, {31'h0, e.fault});
          check(donePhys == e.phys, e.tag, "phys", donePhys, e.phys);
          check(readLog.size() == e.nReads, {e.tag, "/R8"}, "read count",
                readLog.size(), e.nReads);
          if (readLog.size() > 0)
            check(readLog[0] == e.addr0, {e.tag, "/R1"}, "first read address",
                  readLog[0], e.addr0);
        end
        readLog.delete();
        pendReady = 1;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Sparse memory image
    mem[DIR_A + 32'd4]  = TBL_A | 32'h1;          // small-page table
    mem[TBL_A + 32'd4]  = 32'h1234_5E67;          // present, junk flags
    mem[TBL_A + 32'd8]  = 32'h0000_0000;          // absent leaf
    mem[TBL_A + 32'd12] = 32'h00AB_C001;
    mem[DIR_A + 32'd8]  = 32'h4AD5_5081;          // large, junk bits 21:12
    mem[DIR_A + 32'd12] = 32'h0030_0080;          // large flag, not present
    mem[DIR_B + 32'd4]  = 32'h8000_0081;          // large in directory B

    repeat (4) @(negedge clk);
    // R10: reset state
    check(reqReady == 1'b1, "R10", "reqReady in reset", {31'h0, reqReady}, 32'h1);
    check(memReq == 1'b0, "R10", "memReq in reset", {31'h0, memReq}, 32'h0);
    check(doneValid == 1'b0, "R10", "doneValid in reset", {31'h0, doneValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && memReq == 1'b0, "R10", "idle after reset",
          {30'h0, memReq, reqReady}, 32'h1);

    translate(32'h0040_1ABC, DIR_A, "");     // R2 -> 12345ABC
    translate(32'h0089_4321, DIR_A, "");     // R3 -> 4AC94321
    translate(32'h00C0_0123, DIR_A, "");     // R6 present clear, large set
    translate(32'h0040_2FFF, DIR_A, "");     // R7 leaf absent
    translate(32'h0040_3010, DIR_A, "R4");   // small right after large
    translate(32'h0089_4321, DIR_A, "R4");
    translate(32'h0040_1ABC, DIR_B, "R5");   // new base -> 80001ABC
    translate(32'h0040_1ABC, DIR_A, "R5");   // back to A -> 12345ABC
    translate(32'h0100_0000, DIR_A, "");     // R6 entry never written

    for (int i = 0; i < 40; i++) begin
      logic [31:0] lin;
      lin = ((32'(i % 4) + 32'd1) << 22) | ((32'(i % 3) + 32'd1) << 12) | 32'((i * 37) & 12'hFFF);
      translate(lin, (i % 2 == 1) ? DIR_B : DIR_A, "R4");
    end

    while (sbq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule